// File: doc/BRIEF.md
# One-Hot Word Selector with Fallback

This block is a purely combinational selector. A set of candidate words arrives on one packed bus, and a one-hot select vector has one line per candidate. The output word carries the candidate whose line is active. When no line is active, a separate fallback word is passed through instead. The block suits decoded-state datapaths where a one-hot state or grant vector picks a data source, and where the idle condition needs its own defined value.

Several lines may be active at once. This is illegal use, but the block still gives a fixed, checkable result: the output is the bitwise OR of every selected candidate, and the fallback word is left out. A conflict flag is raised at the same time. The selection is built as gating followed by a balanced OR tree. No priority chain is involved, so the logic depth is the same for every select position.

Top module: `onehot_pmux`

## Requirements
- R1: Candidate n occupies bits [n*DATA_W +: DATA_W] of `cand_bus`, for n from 0 to SEL_N-1. Bit n of `sel_hot` belongs to candidate n.
- R2: When every bit of `sel_hot` is 0, `out_word` equals `dflt_word`.
- R3: When exactly bit n of `sel_hot` is 1, `out_word` equals candidate n.
- R4: When two or more bits of `sel_hot` are 1, `out_word` equals the bitwise OR of all selected candidates, and `dflt_word` does not contribute.
- R5: `sel_conflict` is 1 exactly when two or more bits of `sel_hot` are 1, and 0 otherwise.
- R6: While at least one select bit is 1, candidates whose select bit is 0 have no effect on `out_word`.
- R7: While at least one select bit is 1, `dflt_word` has no effect on `out_word`.
- R8: Both outputs depend only on the present inputs. They follow an input change within the same cycle and hold no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dflt_word | input | DATA_W | Fallback word, used when no select line is active |
| cand_bus | input | DATA_W*SEL_N | Packed candidate words, candidate n at slice n |
| sel_hot | input | SEL_N | One-hot select, one bit per candidate |
| out_word | output | DATA_W | Selected word |
| sel_conflict | output | 1 | High when more than one select bit is active |

## Verification
The bench builds two copies of the block. The main copy uses DATA_W=12 and SEL_N=6. Six is not a power of two, so the padded leaves of both reduction trees are exercised, and every single-hot position, the all-zero case and random multi-hot patterns stay within a small stimulus set. The second copy uses DATA_W=4 and SEL_N=1, the degenerate case where each tree has a single leaf and no conflict can occur.

// File: rtl/onehot_pmux_pkg.sv
package onehot_pmux_pkg;

  // Depth of a balanced binary tree that covers n leaves.
  function automatic int tree_depth(input int n);
    if (n <= 1) return 0;
    return $clog2(n);
  endfunction

  // Leaf count of that tree after padding to a power of two.
  function automatic int tree_leaves(input int n);
    return 1 << tree_depth(n);
  endfunction

endpackage

// File: rtl/ohm_slice_gate.sv
// Masks each candidate word with its own select bit (AND stage).
module ohm_slice_gate #(
  parameter int DATA_W = 8,
  parameter int SEL_N  = 4
) (
  input  logic [DATA_W*SEL_N-1:0] cand_bus,
  input  logic [SEL_N-1:0]        sel_hot,
  output logic [DATA_W*SEL_N-1:0] gated_bus
);

  for (genvar n = 0; n < SEL_N; n++) begin : g_lane
    assign gated_bus[n*DATA_W +: DATA_W] =
      cand_bus[n*DATA_W +: DATA_W] & {DATA_W{sel_hot[n]}};
  end

endmodule

// File: rtl/ohm_or_tree.sv
// Balanced OR reduction of LEAVES words (OR stage).
module ohm_or_tree
  import onehot_pmux_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEAVES = 4
) (
  input  logic [DATA_W*LEAVES-1:0] word_bus,
  output logic [DATA_W-1:0]        merged
);

  localparam int PADDED = tree_leaves(LEAVES);
  localparam int NODES  = 2 * PADDED - 1;

  // Heap layout: node k has children 2k+1 and 2k+2, leaves from PADDED-1.
  logic [DATA_W-1:0] node [NODES];

  for (genvar i = 0; i < PADDED; i++) begin : g_leaf
    if (i < LEAVES) begin : g_real
      assign node[PADDED-1+i] = word_bus[i*DATA_W +: DATA_W];
    end else begin : g_pad
      assign node[PADDED-1+i] = '0;
    end
  end

  for (genvar k = 0; k < PADDED - 1; k++) begin : g_inner
    assign node[k] = node[2*k+1] | node[2*k+2];
  end

  assign merged = node[0];

endmodule

// File: rtl/ohm_conflict_tree.sv
// Balanced detector: any line active, and two or more lines active.
module ohm_conflict_tree
  import onehot_pmux_pkg::*;
#(
  parameter int SEL_N = 4
) (
  input  logic [SEL_N-1:0] sel_hot,
  output logic             any_hot,
  output logic             multi_hot
);

  localparam int PADDED = tree_leaves(SEL_N);
  localparam int NODES  = 2 * PADDED - 1;

  logic node_any   [NODES];
  logic node_multi [NODES];

  for (genvar i = 0; i < PADDED; i++) begin : g_leaf
    if (i < SEL_N) begin : g_real
      assign node_any[PADDED-1+i] = sel_hot[i];
    end else begin : g_pad
      assign node_any[PADDED-1+i] = 1'b0;
    end
    assign node_multi[PADDED-1+i] = 1'b0;
  end

  for (genvar k = 0; k < PADDED - 1; k++) begin : g_inner
    assign node_any[k]   = node_any[2*k+1] | node_any[2*k+2];
    assign node_multi[k] = node_multi[2*k+1] | node_multi[2*k+2]
                         | (node_any[2*k+1] & node_any[2*k+2]);
  end

  assign any_hot   = node_any[0];
  assign multi_hot = node_multi[0];

endmodule

// File: rtl/onehot_pmux.sv
module onehot_pmux #(
  parameter int DATA_W = 8,
  parameter int SEL_N  = 4
) (
  input  logic [DATA_W-1:0]       dflt_word,
  input  logic [DATA_W*SEL_N-1:0] cand_bus,
  input  logic [SEL_N-1:0]        sel_hot,
  output logic [DATA_W-1:0]       out_word,
  output logic                    sel_conflict
);

  localparam int BUS_W = DATA_W * SEL_N;

  logic [BUS_W-1:0]  gated_bus;
  logic [DATA_W-1:0] merged;
  logic              any_hot;
  logic              multi_hot;

  ohm_slice_gate #(.DATA_W(DATA_W), .SEL_N(SEL_N)) u_gate (
    .cand_bus  (cand_bus),
    .sel_hot   (sel_hot),
    .gated_bus (gated_bus)
  );

  ohm_or_tree #(.DATA_W(DATA_W), .LEAVES(SEL_N)) u_merge (
    .word_bus (gated_bus),
    .merged   (merged)
  );

  ohm_conflict_tree #(.SEL_N(SEL_N)) u_detect (
    .sel_hot   (sel_hot),
    .any_hot   (any_hot),
    .multi_hot (multi_hot)
  );

  // Fallback enters the OR only when no line is active.
  always_comb begin
    out_word     = merged | (dflt_word & {DATA_W{~any_hot}});
    sel_conflict = multi_hot;
  end

endmodule

// File: rtl/onehot_pmux_chk.sv
module onehot_pmux_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_N  = 4
) (
  input logic [DATA_W-1:0]       dflt_word,
  input logic [DATA_W*SEL_N-1:0] cand_bus,
  input logic [SEL_N-1:0]        sel_hot,
  input logic [DATA_W-1:0]       out_word,
  input logic                    sel_conflict
);

  logic [DATA_W-1:0] union_w;
  logic [DATA_W-1:0] last_w;
  int                hot_cnt;

  always_comb begin
    union_w = '0;
    last_w  = '0;
    for (int n = 0; n < SEL_N; n++) begin
      if (sel_hot[n]) begin
        union_w = union_w | cand_bus[n*DATA_W +: DATA_W];
        last_w  = cand_bus[n*DATA_W +: DATA_W];
      end
    end
    hot_cnt = $countones(sel_hot);

    if (hot_cnt == 0) begin
      assert_idle_fallback_R2: assert (out_word == dflt_word)
        else $error("R2 idle output %h expected %h", out_word, dflt_word);
    end
    if (hot_cnt == 1) begin
      assert_single_pick_R3: assert (out_word == last_w)
        else $error("R3 single-hot output %h expected %h", out_word, last_w);
    end
    if (hot_cnt > 1) begin
      assert_multi_union_R4: assert (out_word == union_w)
        else $error("R4 multi-hot output %h expected %h", out_word, union_w);
    end
    assert_conflict_flag_R5: assert (sel_conflict == (hot_cnt > 1))
      else $error("R5 conflict %b with %0d lines active", sel_conflict, hot_cnt);
  end

endmodule

bind onehot_pmux onehot_pmux_chk #(.DATA_W(DATA_W), .SEL_N(SEL_N)) u_chk (
  .dflt_word    (dflt_word),
  .cand_bus     (cand_bus),
  .sel_hot      (sel_hot),
  .out_word     (out_word),
  .sel_conflict (sel_conflict)
);

// File: tb/onehot_pmux_bench.sv
module onehot_pmux_bench;

  localparam int W  = 12;
  localparam int N  = 6;
  localparam int NW = 4;

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;

  logic [W-1:0]   a_dflt;
  logic [W*N-1:0] a_cand;
  logic [N-1:0]   a_sel;
  logic [W-1:0]   a_out;
  logic           a_conf;

  logic [NW-1:0]  b_dflt;
  logic [NW-1:0]  b_cand;
  logic [0:0]     b_sel;
  logic [NW-1:0]  b_out;
  logic           b_conf;

  onehot_pmux #(.DATA_W(W), .SEL_N(N)) u_onehot_pmux (
    .dflt_word    (a_dflt),
    .cand_bus     (a_cand),
    .sel_hot      (a_sel),
    .out_word     (a_out),
    .sel_conflict (a_conf)
  );

  onehot_pmux #(.DATA_W(NW), .SEL_N(1)) u_onehot_pmux_narrow (
    .dflt_word    (b_dflt),
    .cand_bus     (b_cand),
    .sel_hot      (b_sel),
    .out_word     (b_out),
    .sel_conflict (b_conf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Spec model for the main copy.
  function automatic logic [W-1:0] ref_word(input logic [W-1:0] d,
                                            input logic [W*N-1:0] c,
                                            input logic [N-1:0] s);
    logic [W-1:0] r;
    if (s == '0) return d;
    r = '0;
    for (int n = 0; n < N; n++) if (s[n]) r = r | c[n*W +: W];
    return r;
  endfunction

  function automatic logic ref_conf(input logic [N-1:0] s);
    return $countones(s) > 1;
  endfunction

  function automatic logic [W*N-1:0] rnd_bus();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    return r[W*N-1:0];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_a(input logic [W-1:0] d, input logic [W*N-1:0] c, input logic [N-1:0] s);
    @(posedge clk);
    a_dflt = d;
    a_cand = c;
    a_sel  = s;
    @(negedge clk);
  endtask

  task automatic check_a(input string tag);
    check(tag, a_out, ref_word(a_dflt, a_cand, a_sel));
    check({tag, " conflict R5"}, {{(W-1){1'b0}}, a_conf}, {{(W-1){1'b0}}, ref_conf(a_sel)});
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0]   hold;
    logic [N-1:0]   s;
    logic [W*N-1:0] c;
    checks = 0;
    errors = 0;
    void'($urandom(32'h5eed_0b17));
    rst_n  = 1'b0;
    a_dflt = '0; a_cand = '0; a_sel = '0;
    b_dflt = '0; b_cand = '0; b_sel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Starting state: all inputs zero gives zero output, no conflict.
    @(negedge clk);
    check("reset-state R2", a_out, '0);
    check("reset-state R5", {{(W-1){1'b0}}, a_conf}, '0);

    // R2: all-zero select passes the fallback.
    drive_a(12'hA5C, rnd_bus(), '0);
    check_a("idle R2");
    drive_a(12'hFFF, {(W*N){1'b1}}, '0);
    check_a("idle all-ones bus R2");

    // R1/R3: every single-hot position picks its own slice.
    for (int n = 0; n < N; n++) begin
      c = '0;
      for (int k = 0; k < N; k++) c[k*W +: W] = W'(12'h100 * (k + 1) + k);
      drive_a(12'h3C3, c, N'(1) << n);
      check_a("single-hot slice position R1 R3");
      check("single-hot exact R3", a_out, W'(12'h100 * (n + 1) + n));
    end
    for (int i = 0; i < 24; i++) begin
      drive_a(W'($urandom()), rnd_bus(), N'(1) << (i % N));
      check_a("single-hot random R3");
    end

    // R6/R7: unselected slices and fallback have no effect.
    drive_a(12'h111, rnd_bus(), 6'b000100);
    hold = a_out;
    c = a_cand;
    for (int k = 0; k < N; k++) if (k != 2) c[k*W +: W] = ~c[k*W +: W];
    drive_a(~a_dflt, c, 6'b000100);
    check("unselected slices ignored R6", a_out, hold);
    drive_a(12'h000, c, 6'b000100);
    check("fallback ignored single R7", a_out, hold);

    // R4/R5: two fixed multi-hot patterns, fallback excluded.
    c = '0;
    c[0*W +: W] = 12'h00F;
    c[5*W +: W] = 12'hF00;
    drive_a(12'h0F0, c, 6'b100001);
    check("multi-hot union R4", a_out, 12'hF0F);
    check("multi-hot flag R5", {{(W-1){1'b0}}, a_conf}, 12'h001);
    drive_a(12'hFFF, '0, 6'b111111);
    check("all lines zero bus fallback excluded R4 R7", a_out, 12'h000);

    // Random multi-hot patterns.
    for (int i = 0; i < 200; i++) begin
      s = N'($urandom());
      if ($countones(s) < 2) s = s | (N'(3) << ($urandom() % (N - 1)));
      drive_a(W'($urandom()), rnd_bus(), s);
      check_a("random multi-hot R4");
    end

    // R8: output follows a change with no clock edge in between.
    a_sel = 6'b001000;
    #1;
    check("same-cycle follow R8", a_out, a_cand[3*W +: W]);

    // Narrow copy, single candidate.
    @(posedge clk);
    b_dflt = 4'h9; b_cand = 4'h6; b_sel = 1'b0;
    @(negedge clk);
    check("narrow idle R2", {{(W-NW){1'b0}}, b_out}, 12'h009);
    @(posedge clk);
    b_sel = 1'b1;
    @(negedge clk);
    check("narrow pick R3", {{(W-NW){1'b0}}, b_out}, 12'h006);
    check("narrow no conflict R5", {{(W-1){1'b0}}, b_conf}, '0);
    @(posedge clk);
    b_dflt = 4'h0;
    @(negedge clk);
    check("narrow fallback ignored R7", {{(W-NW){1'b0}}, b_out}, 12'h006);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule